// File: doc/BRIEF.md
# Speculative Transaction Line Buffer

This block holds every memory line that a running transaction touches. A processor-side port carries loads, stores and three transaction commands: open, close and cancel. Each line is kept in a small fully associative array. An entry stores the line's address, the value memory held when the line was first touched, the value the transaction has since written, and flags for read and written. While a transaction runs, no store reaches memory. The first touch of a line fetches it from the memory read port, and later accesses are served from the array.

A transaction ends in one of two ways. If the close command arrives while every touched line is still held, the block scans its entries in index order and writes back each written line whose value changed, one line per cycle. It then reports the transaction as committed. The transaction is cancelled in any of these cases: an explicit cancel command, an invalidation from another agent that hits a held line, a preemption pulse, or an access to a new line when the array is full. In that case every entry is dropped in one cycle and memory keeps its old contents. A doomed flag tells software at any time that the current attempt has failed.

The controller has five states:
- IDLE: after reset.
- RUN: a transaction is open.
- FLUSH: committing, writing back lines.
- DONE: the last transaction committed.
- FAIL: the last transaction aborted.

The transitions are:
- IDLE, DONE or FAIL go to RUN on an open command.
- RUN goes to FAIL on any abort cause.
- RUN goes to FLUSH on a close command.
- FLUSH goes to DONE after the last entry has been scanned.

Top module: `txn_line_buffer`

## Requirements
- R1: After reset, txn_status is 0 (idle), txn_doomed is 0, cmd_ready is 1 and mem_wr_en is 0.
- R2: The command codes are NOP=0, LOAD=1, STORE=2, BEGIN=3, COMMIT=4 and ABORT=5. The status codes are 0 idle, 1 running, 2 committed and 3 aborted. An accepted BEGIN outside RUN empties the array, and txn_status reads 1 after the clock edge.
- R3: In RUN, stores never drive mem_wr_en. A later load of the same address returns the speculative value, and memory keeps its old value until commit.
- R4: After COMMIT, cmd_ready is 0 for NUM_ENT cycles while entries are scanned from index 0 upwards. Entries are allocated in first-touch order. Each written entry whose new value differs from its old value produces one memory write. Read-only lines and unchanged lines produce none. Afterwards txn_status is 2.
- R5: ABORT in RUN sets txn_status to 3 and txn_doomed to 1 without any memory write. Later loads return the pre-transaction memory values.
- R6: In RUN, a snoop_valid whose snoop_addr matches a held line aborts the transaction at the next edge. A snoop to an address that is not held has no effect.
- R7: A preempt pulse in RUN aborts the transaction at the next edge, and no buffered write reaches memory.
- R8: In RUN, a load or store to a new line when all NUM_ENT entries are valid aborts the transaction and is discarded. An access that hits a held line while the array is full proceeds.
- R9: In IDLE or DONE, a store writes memory in the cycle it is accepted, and a load reads memory.
- R10: In FAIL, stores are dropped and COMMIT leaves txn_status at 3. BEGIN opens a new transaction.
- R11: An accepted load that does not abort gives rsp_valid=1 in the next cycle, with the data in rsp_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | AW | Word address for load or store |
| cmd_wdata | input | DW | Store data |
| cmd_ready | output | 1 | Low while the commit write-back runs |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | DW | Load result |
| snoop_valid | input | 1 | Invalidation from another agent |
| snoop_addr | input | AW | Invalidated address |
| preempt | input | 1 | Interrupt or preemption pulse |
| txn_status | output | 2 | 0 idle, 1 running, 2 committed, 3 aborted |
| txn_doomed | output | 1 | Current transaction has failed |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DW | Memory read data, combinational |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write data |

## Verification
On every cycle, the assertions check four things:
- No memory write happens while a transaction is running or after it has aborted.
- A hitting snoop, or an access to a new line when the array is full, leads to the aborted status.
- The write-back index advances by one each cycle.
- Every response follows an accepted load.

Only the bench scenarios can show the rest. This covers the exact order and content of the write-back, the skipping of silent stores, and the return of old values after an abort. It also covers direct access outside a transaction and the sweep over every fill level from zero to a full array.

// File: rtl/txb_pkg.sv
package txb_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_LOAD   = 3'd1,
        OP_STORE  = 3'd2,
        OP_BEGIN  = 3'd3,
        OP_COMMIT = 3'd4,
        OP_ABORT  = 3'd5
    } txb_op_e;

    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_RUN  = 2'd1,
        TS_DONE = 2'd2,
        TS_FAIL = 2'd3
    } txb_status_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_FLUSH,
        ST_DONE,
        ST_FAIL
    } txb_state_e;
endpackage

// File: rtl/txb_line_array.sv
module txb_line_array #(
    parameter int NUM_ENT = 8,
    parameter int AW      = 16,
    parameter int DW      = 32,
    parameter int IW      = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_all,
    input  logic          acc_en,
    input  logic          acc_store,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    input  logic [DW-1:0] fill_data,
    input  logic [AW-1:0] snoop_addr,
    input  logic [IW-1:0] scan_idx,
    output logic          hit,
    output logic [DW-1:0] hit_data,
    output logic          full,
    output logic          snoop_hit,
    output logic          scan_valid,
    output logic          scan_written,
    output logic          scan_dirty,
    output logic [AW-1:0] scan_addr,
    output logic [DW-1:0] scan_data
);
    logic [NUM_ENT-1:0] ent_v, ent_rd, ent_wr;
    logic [AW-1:0]      ent_tag [NUM_ENT];
    logic [DW-1:0]      ent_old [NUM_ENT];
    logic [DW-1:0]      ent_new [NUM_ENT];
    logic [NUM_ENT-1:0] acc_match, snp_match;
    logic [IW-1:0]      hit_idx, free_idx;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        assign acc_match[g] = ent_v[g] && (ent_tag[g] == acc_addr);
        assign snp_match[g] = ent_v[g] && (ent_rd[g] || ent_wr[g]) &&
                              (ent_tag[g] == snoop_addr);
    end

    assign hit       = |acc_match;
    assign snoop_hit = |snp_match;
    assign full      = &ent_v;

    always_comb begin
        hit_idx  = '0;
        hit_data = '0;
        free_idx = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (acc_match[i]) begin
                hit_idx  = IW'(i);
                hit_data = ent_new[i];
            end
        end
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (!ent_v[i]) free_idx = IW'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_v  <= '0;
            ent_rd <= '0;
            ent_wr <= '0;
        end else if (clear_all) begin
            ent_v  <= '0;
            ent_rd <= '0;
            ent_wr <= '0;
        end else if (acc_en) begin
            if (hit) begin
                if (acc_store) ent_wr[hit_idx] <= 1'b1;
                else           ent_rd[hit_idx] <= 1'b1;
            end else if (!full) begin
                ent_v[free_idx]  <= 1'b1;
                ent_rd[free_idx] <= !acc_store;
                ent_wr[free_idx] <= acc_store;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (acc_en && !clear_all) begin
            if (hit) begin
                if (acc_store) ent_new[hit_idx] <= acc_wdata;
            end else if (!full) begin
                ent_tag[free_idx] <= acc_addr;
                ent_old[free_idx] <= fill_data;
                ent_new[free_idx] <= acc_store ? acc_wdata : fill_data;
            end
        end
    end

    assign scan_valid   = ent_v[scan_idx];
    assign scan_written = ent_wr[scan_idx];
    assign scan_dirty   = ent_new[scan_idx] != ent_old[scan_idx];
    assign scan_addr    = ent_tag[scan_idx];
    assign scan_data    = ent_new[scan_idx];
endmodule

// File: rtl/txb_fsm.sv
module txb_fsm
    import txb_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int IW      = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic          hit,
    input  logic          full,
    input  logic          snoop_valid,
    input  logic          snoop_hit,
    input  logic          preempt,
    input  logic          scan_valid,
    input  logic          scan_written,
    input  logic          scan_dirty,
    output logic [IW-1:0] scan_idx,
    output logic          cmd_ready,
    output logic          clear_all,
    output logic          acc_en,
    output logic          acc_store,
    output logic          load_fire,
    output logic          direct_wr,
    output logic          flush_wr,
    output logic [1:0]    status
);
    txb_state_e state_q, state_d;
    logic fire, is_acc, abort_evt, last_scan;

    assign fire      = cmd_valid && (state_q != ST_FLUSH);
    assign is_acc    = (cmd_op == OP_LOAD) || (cmd_op == OP_STORE);
    assign abort_evt = (state_q == ST_RUN) &&
                       (preempt || (snoop_valid && snoop_hit) ||
                        (fire && cmd_op == OP_ABORT) ||
                        (fire && is_acc && !hit && full));
    assign last_scan = scan_idx == IW'(NUM_ENT - 1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: if (fire && cmd_op == OP_BEGIN) state_d = ST_RUN;
            ST_RUN: begin
                if (abort_evt)                         state_d = ST_FAIL;
                else if (fire && cmd_op == OP_COMMIT)  state_d = ST_FLUSH;
            end
            ST_FLUSH: if (last_scan) state_d = ST_DONE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            scan_idx <= '0;
        end else begin
            state_q  <= state_d;
            scan_idx <= (state_q == ST_FLUSH && !last_scan) ? scan_idx + 1'b1 : '0;
        end
    end

    always_comb begin
        cmd_ready = state_q != ST_FLUSH;
        clear_all = (state_d != state_q) &&
                    (state_d == ST_RUN || state_d == ST_FAIL || state_d == ST_DONE);
        acc_en    = (state_q == ST_RUN) && fire && is_acc && !abort_evt;
        acc_store = cmd_op == OP_STORE;
        load_fire = fire && (cmd_op == OP_LOAD) && !abort_evt;
        direct_wr = fire && (cmd_op == OP_STORE) &&
                    (state_q == ST_IDLE || state_q == ST_DONE);
        flush_wr  = (state_q == ST_FLUSH) && scan_valid && scan_written && scan_dirty;
        unique case (state_q)
            ST_RUN, ST_FLUSH: status = TS_RUN;
            ST_DONE:          status = TS_DONE;
            ST_FAIL:          status = TS_FAIL;
            default:          status = TS_IDLE;
        endcase
    end

    // R4
    flush_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH && scan_idx != '0) |->
            ($past(state_q) == ST_FLUSH && scan_idx == $past(scan_idx) + 1'b1));
endmodule

// File: rtl/txn_line_buffer.sv
module txn_line_buffer
    import txb_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int AW      = 16,
    parameter int DW      = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          cmd_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    input  logic          preempt,
    output logic [1:0]    txn_status,
    output logic          txn_doomed,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [DW-1:0] mem_rd_data,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data
);
    localparam int IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    logic          clear_all, acc_en, acc_store, load_fire, direct_wr, flush_wr;
    logic          hit, full, snoop_hit, scan_valid, scan_written, scan_dirty;
    logic [DW-1:0] hit_data, scan_data;
    logic [AW-1:0] scan_addr;
    logic [IW-1:0] scan_idx;

    txb_line_array #(.NUM_ENT(NUM_ENT), .AW(AW), .DW(DW), .IW(IW)) u_array (
        .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
        .acc_en(acc_en), .acc_store(acc_store), .acc_addr(cmd_addr),
        .acc_wdata(cmd_wdata), .fill_data(mem_rd_data), .snoop_addr(snoop_addr),
        .scan_idx(scan_idx), .hit(hit), .hit_data(hit_data), .full(full),
        .snoop_hit(snoop_hit), .scan_valid(scan_valid), .scan_written(scan_written),
        .scan_dirty(scan_dirty), .scan_addr(scan_addr), .scan_data(scan_data)
    );

    txb_fsm #(.NUM_ENT(NUM_ENT), .IW(IW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .hit(hit), .full(full), .snoop_valid(snoop_valid), .snoop_hit(snoop_hit),
        .preempt(preempt), .scan_valid(scan_valid), .scan_written(scan_written),
        .scan_dirty(scan_dirty), .scan_idx(scan_idx), .cmd_ready(cmd_ready),
        .clear_all(clear_all), .acc_en(acc_en), .acc_store(acc_store),
        .load_fire(load_fire), .direct_wr(direct_wr), .flush_wr(flush_wr),
        .status(txn_status)
    );

    assign txn_doomed  = txn_status == TS_FAIL;
    assign mem_rd_addr = cmd_addr;
    assign mem_wr_en   = direct_wr || flush_wr;
    assign mem_wr_addr = flush_wr ? scan_addr : cmd_addr;
    assign mem_wr_data = flush_wr ? scan_data : cmd_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= load_fire;
            if (load_fire) rsp_data <= hit ? hit_data : mem_rd_data;
        end
    end

    // R3
    no_spec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_status == TS_RUN && cmd_ready) |-> !mem_wr_en);

    // R5
    no_fail_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_status == TS_FAIL) |-> !mem_wr_en);

    // R6
    snoop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_status == TS_RUN && cmd_ready && snoop_valid && snoop_hit) |=>
            (txn_status == TS_FAIL));

    // R8
    overflow_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_status == TS_RUN && cmd_ready && cmd_valid && !hit && full &&
         (cmd_op == OP_LOAD || cmd_op == OP_STORE)) |=> (txn_status == TS_FAIL));

    // R11
    rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_valid && cmd_ready && cmd_op == OP_LOAD));
endmodule

// File: tb/txn_line_buffer_bench.sv
`timescale 1ns/1ps
module txn_line_buffer_bench;
    localparam int NE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] cmd_addr = '0;
    logic [31:0] cmd_wdata = '0;
    logic        cmd_ready, rsp_valid;
    logic [31:0] rsp_data;
    logic        snoop_valid = 1'b0;
    logic [15:0] snoop_addr = '0;
    logic        preempt = 1'b0;
    logic [1:0]  txn_status;
    logic        txn_doomed;
    logic [15:0] mem_rd_addr, mem_wr_addr;
    logic [31:0] mem_rd_data, mem_wr_data;
    logic        mem_wr_en;

    logic [31:0] bmem [256];
    logic [15:0] wlog_a [64];
    logic [31:0] wlog_d [64];
    int          wlog_n;
    int          nchk = 0;
    int          nerr = 0;
    logic        timed_out = 1'b0;

    always #2.5 clk = ~clk;

    txn_line_buffer u_txn_line_buffer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .snoop_valid(snoop_valid),
        .snoop_addr(snoop_addr), .preempt(preempt), .txn_status(txn_status),
        .txn_doomed(txn_doomed), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    function automatic logic [31:0] init_val(input logic [15:0] a);
        return 32'hC000_0000 | (32'(a) * 32'd13);
    endfunction

    assign mem_rd_data = bmem[mem_rd_addr[7:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bmem[i] <= init_val(16'(i));
            wlog_n <= 0;
        end else if (mem_wr_en) begin
            bmem[mem_wr_addr[7:0]] <= mem_wr_data;
            wlog_a[wlog_n % 64]    <= mem_wr_addr;
            wlog_d[wlog_n % 64]    <= mem_wr_data;
            wlog_n                 <= wlog_n + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        @(posedge clk); #1;
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic load_chk(input string tag, input logic [15:0] a, input logic [31:0] exp);
        issue(3'd1, a, 32'h0);
        check({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " rsp_data"}, rsp_data, exp);
    endtask

    task automatic snoop(input logic [15:0] a);
        @(negedge clk); snoop_valid = 1'b1; snoop_addr = a;
        @(posedge clk); #1; snoop_valid = 1'b0;
    endtask

    task automatic wait_ready();
        while (cmd_ready !== 1'b1) begin @(posedge clk); #1; end
    endtask

    task automatic run_all();
        int base;
        logic [15:0] a;
        // R1 reset state
        check("R1 status", 32'(txn_status), 32'd0);
        check("R1 doomed", 32'(txn_doomed), 32'd0);
        check("R1 ready", 32'(cmd_ready), 32'd1);
        check("R1 wr_en", 32'(mem_wr_en), 32'd0);

        // R9 direct access outside a transaction
        issue(3'd2, 16'd10, 32'h1234_5678);
        check("R9 store reaches memory", bmem[10], 32'h1234_5678);
        load_chk("R9 R11 load", 16'd10, 32'h1234_5678);

        // R2 R3 R4 commit with read-only and silent lines
        issue(3'd3, 16'd0, 32'd0);
        check("R2 running", 32'(txn_status), 32'd1);
        load_chk("R3 first load", 16'd20, init_val(16'd20));
        issue(3'd2, 16'd21, 32'hAAAA_0001);
        issue(3'd2, 16'd22, 32'hAAAA_0002);
        issue(3'd2, 16'd20, 32'hAAAA_0003);
        issue(3'd2, 16'd23, init_val(16'd23));
        load_chk("R3 spec load", 16'd21, 32'hAAAA_0001);
        check("R3 memory untouched", bmem[21], init_val(16'd21));
        base = wlog_n;
        issue(3'd4, 16'd0, 32'd0);
        check("R4 ready low", 32'(cmd_ready), 32'd0);
        wait_ready();
        check("R4 status done", 32'(txn_status), 32'd2);
        check("R4 write count", 32'(wlog_n - base), 32'd3);
        check("R4 order a0", 32'(wlog_a[base % 64]), 32'd20);
        check("R4 order d0", wlog_d[base % 64], 32'hAAAA_0003);
        check("R4 order a1", 32'(wlog_a[(base + 1) % 64]), 32'd21);
        check("R4 order a2", 32'(wlog_a[(base + 2) % 64]), 32'd22);

        // R5 R10 explicit abort
        issue(3'd3, 16'd0, 32'd0);
        issue(3'd2, 16'd30, 32'hBBBB_0000);
        load_chk("R3 hit after store", 16'd30, 32'hBBBB_0000);
        base = wlog_n;
        issue(3'd5, 16'd0, 32'd0);
        check("R5 aborted", 32'(txn_status), 32'd3);
        check("R5 doomed", 32'(txn_doomed), 32'd1);
        load_chk("R5 old value", 16'd30, init_val(16'd30));
        issue(3'd2, 16'd30, 32'hBBBB_1111);
        check("R10 store dropped", bmem[30], init_val(16'd30));
        issue(3'd4, 16'd0, 32'd0);
        check("R10 commit in fail", 32'(txn_status), 32'd3);
        check("R5 no writes", 32'(wlog_n - base), 32'd0);

        // R6 snoop conflicts
        issue(3'd3, 16'd0, 32'd0);
        check("R10 restart", 32'(txn_status), 32'd1);
        load_chk("R6 load", 16'd40, init_val(16'd40));
        snoop(16'd41);
        check("R6 miss snoop ignored", 32'(txn_status), 32'd1);
        snoop(16'd40);
        check("R6 read-line snoop", 32'(txn_status), 32'd3);
        issue(3'd3, 16'd0, 32'd0);
        issue(3'd2, 16'd50, 32'hCCCC_0000);
        snoop(16'd50);
        check("R6 written-line snoop", 32'(txn_status), 32'd3);
        check("R6 memory kept", bmem[50], init_val(16'd50));

        // R7 preemption
        issue(3'd3, 16'd0, 32'd0);
        issue(3'd2, 16'd60, 32'hDDDD_0000);
        @(negedge clk); preempt = 1'b1;
        @(posedge clk); #1; preempt = 1'b0;
        check("R7 aborted", 32'(txn_status), 32'd3);
        check("R7 memory kept", bmem[60], init_val(16'd60));

        // R8 capacity overflow
        issue(3'd3, 16'd0, 32'd0);
        for (int j = 0; j < NE; j++) issue(3'd2, 16'(70 + j), 32'hE000_0000 + 32'(j));
        check("R8 full still running", 32'(txn_status), 32'd1);
        issue(3'd2, 16'd70, 32'hE000_00FF);
        check("R8 hit when full", 32'(txn_status), 32'd1);
        issue(3'd1, 16'(70 + NE), 32'd0);
        check("R8 overflow aborts", 32'(txn_status), 32'd3);
        check("R8 no response", 32'(rsp_valid), 32'd0);
        check("R8 memory kept", bmem[70], init_val(16'd70));

        // R4 sweep over every fill level
        for (int n = 0; n <= NE; n++) begin
            issue(3'd3, 16'd0, 32'd0);
            for (int j = 0; j < n; j++) begin
                a = 16'(128 + n * 12 + j);
                issue(3'd2, a, 32'h5000_0000 + 32'(n * 256 + j));
            end
            base = wlog_n;
            issue(3'd4, 16'd0, 32'd0);
            wait_ready();
            check("R4 sweep status", 32'(txn_status), 32'd2);
            check("R4 sweep count", 32'(wlog_n - base), 32'(n));
            for (int j = 0; j < n; j++) begin
                check("R4 sweep addr", 32'(wlog_a[(base + j) % 64]), 32'(128 + n * 12 + j));
                check("R4 sweep data", wlog_d[(base + j) % 64], 32'h5000_0000 + 32'(n * 256 + j));
            end
        end
        issue(3'd2, 16'd5, 32'h0BAD_F00D);
        check("R9 store after commit", bmem[5], 32'h0BAD_F00D);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        fork
            run_all();
            begin #1_000_000; timed_out = 1'b1; end
        join_any
        disable fork;
        if (timed_out) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=hung expected=finish");
        end
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule